// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block times one SPI master frame from the system clock. A frame engine strobes `start_i`. The timer then runs the frame as a fixed sequence of phases:

1. A lead delay from chip-select assertion to the first clock edge.
2. The data-bit phase, during which it pulses a serial-clock toggle enable once per half period.
3. A trail delay after the last clock edge.
4. An inter-frame gap.

Each delay phase ends with a one-cycle done pulse.

The serial clock period comes from a cascade of two stages. A 2-bit baud prescaler index picks a divide of 2, 3, 5 or 7. A 4-bit baud scaler index picks a divide from a table that starts 2, 4, 6, 8 and then continues with powers of two up to 32768. An optional double-rate bit halves the period.

The three delays are set the same way, each by its own 2-bit prescaler and 4-bit scaler field. All configuration is captured when a frame is accepted. A frame in progress therefore keeps its timing, whatever happens on the configuration inputs.

Top module: `spi_tmg_gen`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `sck_tgl_o`, `lead_done_o`, `trail_done_o` and `gap_done_o` are all 0 until a frame is started.
- R2: `start_i` seen at a clock edge while `busy_o` is 0 starts a frame, and `busy_o` is 1 from the next cycle. `start_i` while `busy_o` is 1 has no effect on the running frame.
- R3: The lead delay lasts Nl = dp(lead_pre_i) × ds(lead_scl_i) cycles, where dp(i) = 2i+1 (1, 3, 5, 7) and ds(i) = 2^(i+1). Counting the cycle after the accepting edge as cycle 1, `lead_done_o` is 1 exactly in cycle Nl.
- R4: In the bit phase the period is P = bp × bs / (1 + dbl_rate_i). Here bp is 2, 3, 5 or 7 for `baud_pre_i` 0 to 3. bs is 2·(i+1) for `baud_scl_i` i < 4 and 2^i for i ≥ 4. `sck_tgl_o` pulses in the cycles Nl + k where k mod P is Hh or 0, with k ≥ 1.
- R5: Each period splits into a first half Hh = ceil(P/2) and a second half floor(P/2). With `dbl_rate_i` 0 the two halves are equal. With it 1 they may differ by one cycle. The fastest setting (indices 0, 0, double rate) toggles every cycle.
- R6: The bit phase lasts until `bits_done_i` is seen at an edge. The trail delay starts in the next cycle, with no further toggles.
- R7: The trail delay lasts dp(trail_pre_i) × ds(trail_scl_i) cycles, and `trail_done_o` is 1 in its last cycle.
- R8: The gap delay lasts dp(gap_pre_i) × ds(gap_scl_i) cycles, and `gap_done_o` is 1 in its last cycle. `busy_o` is 0 from the following cycle.
- R9: Configuration inputs are sampled only at the edge that accepts `start_i`. Changes during a frame do not alter its timing.
- R10: In any cycle at most one of `sck_tgl_o`, `lead_done_o`, `trail_done_o` and `gap_done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe |
| bits_done_i | input | 1 | End-of-bits strobe from the frame engine |
| baud_pre_i | input | 2 | Baud prescaler index |
| baud_scl_i | input | 4 | Baud scaler index |
| dbl_rate_i | input | 1 | Double-rate mode |
| lead_pre_i | input | 2 | Lead delay prescaler index |
| lead_scl_i | input | 4 | Lead delay scaler index |
| trail_pre_i | input | 2 | Trail delay prescaler index |
| trail_scl_i | input | 4 | Trail delay scaler index |
| gap_pre_i | input | 2 | Gap delay prescaler index |
| gap_scl_i | input | 4 | Gap delay scaler index |
| busy_o | output | 1 | Frame in progress |
| sck_tgl_o | output | 1 | Serial clock toggle enable |
| lead_done_o | output | 1 | Last cycle of the lead delay |
| trail_done_o | output | 1 | Last cycle of the trail delay |
| gap_done_o | output | 1 | Last cycle of the gap delay |

## Verification
A wrong phase or counter state shows up within one period at the ports, as a done pulse or toggle in the wrong cycle. Every pulse position is fixed by the captured indices, so a one-cycle slip is caught in the cycle it happens. A fault in configuration capture moves the whole remaining frame. It is exposed by scrambling the inputs mid-frame and seeing the next pulse shift. Odd periods in double-rate mode separate the two half lengths. A swap of the halves or a wrong ceiling shows at the first toggle.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

  parameter int PRE_W   = 2;
  parameter int SCL_W   = 4;
  parameter int NUM_DLY = 3;

  localparam int DLY_LEAD  = 0;
  localparam int DLY_TRAIL = 1;
  localparam int DLY_GAP   = 2;

  // longest delay: prescale 7 times 2^(max index + 1)
  localparam int DLY_MAX = 7 * (1 << (2 ** SCL_W));
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_BITS,
    PH_TRAIL,
    PH_GAP
  } phase_e;

  typedef struct packed {
    logic [PRE_W-1:0]              baud_pre;
    logic [SCL_W-1:0]              baud_scl;
    logic                          dbl;
    logic [NUM_DLY-1:0][PRE_W-1:0] dly_pre;
    logic [NUM_DLY-1:0][SCL_W-1:0] dly_scl;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    baud_pre: '0,
    baud_scl: SCL_W'(6),
    dbl:      1'b0,
    dly_pre:  '0,
    dly_scl:  {SCL_W'(1), SCL_W'(0), SCL_W'(0)}
  };

  function automatic cnt_t baud_pre_val(logic [PRE_W-1:0] idx);
    case (idx)
      PRE_W'(0): return cnt_t'(2);
      PRE_W'(1): return cnt_t'(3);
      PRE_W'(2): return cnt_t'(5);
      default:   return cnt_t'(7);
    endcase
  endfunction

  function automatic cnt_t baud_scl_val(logic [SCL_W-1:0] idx);
    if (int'(idx) < 4) return cnt_t'(2 * (int'(idx) + 1));
    return cnt_t'(1) << int'(idx);
  endfunction

  function automatic cnt_t dly_pre_val(logic [PRE_W-1:0] idx);
    return cnt_t'(2 * int'(idx) + 1);
  endfunction

  function automatic cnt_t dly_scl_val(logic [SCL_W-1:0] idx);
    return cnt_t'(1) << (int'(idx) + 1);
  endfunction

endpackage

// File: rtl/spi_tmg_dly_len.sv
module spi_tmg_dly_len
  import spi_tmg_pkg::*;
(
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SCL_W-1:0] scl_i,
  output cnt_t             len_o
);

  cnt_t pre_v, scl_v;

  always_comb begin
    pre_v = dly_pre_val(pre_i);
    scl_v = dly_scl_val(scl_i);
    len_o = pre_v * scl_v;
  end

endmodule

// File: rtl/spi_tmg_baud_len.sv
module spi_tmg_baud_len
  import spi_tmg_pkg::*;
(
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SCL_W-1:0] scl_i,
  input  logic             dbl_i,
  output cnt_t             hhi_o,
  output cnt_t             hlo_o
);

  cnt_t per_full, per;

  always_comb begin
    per_full = baud_pre_val(pre_i) * baud_scl_val(scl_i);
    per      = dbl_i ? (per_full >> 1) : per_full;
    // odd period: the leading half takes the extra cycle
    hhi_o    = (per + cnt_t'(1)) >> 1;
    hlo_o    = per >> 1;
  end

endmodule

// File: rtl/spi_tmg_seq.sv
module spi_tmg_seq
  import spi_tmg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     bits_done_i,
  input  cnt_t [NUM_DLY-1:0]       dly_len_i,
  input  cnt_t                     hhi_i,
  input  cnt_t                     hlo_i,
  output phase_e                   phase_o,
  output logic                     sck_tgl_o,
  output logic [NUM_DLY-1:0]       done_o
);

  phase_e phase_q;
  cnt_t   cnt_q, cur_len;
  logic   half_q, last;

  always_comb begin
    unique case (phase_q)
      PH_LEAD:  cur_len = dly_len_i[DLY_LEAD];
      PH_BITS:  cur_len = half_q ? hlo_i : hhi_i;
      PH_TRAIL: cur_len = dly_len_i[DLY_TRAIL];
      PH_GAP:   cur_len = dly_len_i[DLY_GAP];
      default:  cur_len = cnt_t'(1);
    endcase
    last = (cnt_q == cur_len - cnt_t'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_LEAD;
          cnt_q   <= '0;
        end
        PH_LEAD: if (last) begin
          phase_q <= PH_BITS;
          cnt_q   <= '0;
          half_q  <= 1'b0;
        end else cnt_q <= cnt_q + cnt_t'(1);
        PH_BITS: if (bits_done_i) begin
          phase_q <= PH_TRAIL;
          cnt_q   <= '0;
        end else if (last) begin
          cnt_q   <= '0;
          half_q  <= ~half_q;
        end else cnt_q <= cnt_q + cnt_t'(1);
        PH_TRAIL: if (last) begin
          phase_q <= PH_GAP;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + cnt_t'(1);
        PH_GAP: if (last) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + cnt_t'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o           = phase_q;
  assign sck_tgl_o         = (phase_q == PH_BITS) && last;
  assign done_o[DLY_LEAD]  = (phase_q == PH_LEAD) && last;
  assign done_o[DLY_TRAIL] = (phase_q == PH_TRAIL) && last;
  assign done_o[DLY_GAP]   = (phase_q == PH_GAP) && last;

endmodule

// File: rtl/spi_tmg_gen.sv
module spi_tmg_gen
  import spi_tmg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bits_done_i,
  input  logic [PRE_W-1:0] baud_pre_i,
  input  logic [SCL_W-1:0] baud_scl_i,
  input  logic             dbl_rate_i,
  input  logic [PRE_W-1:0] lead_pre_i,
  input  logic [SCL_W-1:0] lead_scl_i,
  input  logic [PRE_W-1:0] trail_pre_i,
  input  logic [SCL_W-1:0] trail_scl_i,
  input  logic [PRE_W-1:0] gap_pre_i,
  input  logic [SCL_W-1:0] gap_scl_i,
  output logic             busy_o,
  output logic             sck_tgl_o,
  output logic             lead_done_o,
  output logic             trail_done_o,
  output logic             gap_done_o
);

  cfg_t               cfg_d, cfg_q;
  cnt_t [NUM_DLY-1:0] dly_len;
  cnt_t               hhi, hlo;
  phase_e             phase;
  logic [NUM_DLY-1:0] done;

  always_comb begin
    cfg_d.baud_pre           = baud_pre_i;
    cfg_d.baud_scl           = baud_scl_i;
    cfg_d.dbl                = dbl_rate_i;
    cfg_d.dly_pre[DLY_LEAD]  = lead_pre_i;
    cfg_d.dly_scl[DLY_LEAD]  = lead_scl_i;
    cfg_d.dly_pre[DLY_TRAIL] = trail_pre_i;
    cfg_d.dly_scl[DLY_TRAIL] = trail_scl_i;
    cfg_d.dly_pre[DLY_GAP]   = gap_pre_i;
    cfg_d.dly_scl[DLY_GAP]   = gap_scl_i;
  end

  assign busy_o = (phase != PH_IDLE);

  // capture only when a frame is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= CFG_RST;
    else if (start_i && !busy_o) cfg_q <= cfg_d;
  end

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
    spi_tmg_dly_len i_len (
      .pre_i (cfg_q.dly_pre[g]),
      .scl_i (cfg_q.dly_scl[g]),
      .len_o (dly_len[g])
    );
  end

  spi_tmg_baud_len i_baud (
    .pre_i (cfg_q.baud_pre),
    .scl_i (cfg_q.baud_scl),
    .dbl_i (cfg_q.dbl),
    .hhi_o (hhi),
    .hlo_o (hlo)
  );

  spi_tmg_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bits_done_i (bits_done_i),
    .dly_len_i   (dly_len),
    .hhi_i       (hhi),
    .hlo_i       (hlo),
    .phase_o     (phase),
    .sck_tgl_o   (sck_tgl_o),
    .done_o      (done)
  );

  assign lead_done_o  = done[DLY_LEAD];
  assign trail_done_o = done[DLY_TRAIL];
  assign gap_done_o   = done[DLY_GAP];

endmodule

// File: rtl/spi_tmg_chk.sv
module spi_tmg_chk
  import spi_tmg_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   start_i,
  input logic   bits_done_i,
  input logic   busy_i,
  input logic   sck_tgl_i,
  input logic   lead_done_i,
  input logic   trail_done_i,
  input logic   gap_done_i,
  input phase_e phase_i,
  input cfg_t   cfg_i,
  input cnt_t   hhi_i,
  input cnt_t   hlo_i
);

  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (phase_i == PH_LEAD));

  a_r3_lead_to_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_done_i |=> (phase_i == PH_BITS));

  a_r4_tgl_in_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_tgl_i |-> (phase_i == PH_BITS));

  a_r5_even_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == PH_BITS) && !cfg_i.dbl) |-> (hhi_i == hlo_i));

  a_r6_bits_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == PH_BITS) && bits_done_i) |=> (phase_i == PH_TRAIL));

  a_r7_trail_to_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_done_i |=> (phase_i == PH_GAP));

  a_r8_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !gap_done_i) |=> busy_i);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_done_i |=> !busy_i);

  a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cfg_i));

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sck_tgl_i, lead_done_i, trail_done_i, gap_done_i}));

endmodule

bind spi_tmg_gen spi_tmg_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .bits_done_i  (bits_done_i),
  .busy_i       (busy_o),
  .sck_tgl_i    (sck_tgl_o),
  .lead_done_i  (lead_done_o),
  .trail_done_i (trail_done_o),
  .gap_done_i   (gap_done_o),
  .phase_i      (phase),
  .cfg_i        (cfg_q),
  .hhi_i        (hhi),
  .hlo_i        (hlo)
);

// File: tb/test_spi_tmg_gen.sv
module test_spi_tmg_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, bits_done_i = 1'b0, dbl_rate_i = 1'b0;
  logic [1:0] baud_pre_i = '0, lead_pre_i = '0, trail_pre_i = '0, gap_pre_i = '0;
  logic [3:0] baud_scl_i = '0, lead_scl_i = '0, trail_scl_i = '0, gap_scl_i = '0;
  logic       busy_o, sck_tgl_o, lead_done_o, trail_done_o, gap_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  spi_tmg_gen i_spi_tmg_gen (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: act %0d cycles, exp <= 200000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  function automatic int bp_v(int i);
    case (i)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int bs_v(int i);
    return (i < 4) ? 2 * (i + 1) : (1 << i);
  endfunction

  function automatic int dly_v(int p, int s);
    return (2 * p + 1) * (1 << (s + 1));
  endfunction

  task automatic chk(string tag, int bad, int t, int act, int exp);
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: %0d bad cycles, first t=%0d act %0d exp %0d", tag, bad, t, act, exp);
    end
  endtask

  task automatic run_frame(int bp, int bs, int dbl, int lp, int ls, int tp, int ts,
                           int gp, int gs, int nper, bit scramble, bit restart);
    int nl, p, hh, tb_end, nt, ng, t_end;
    int b_lead, b_tgl, b_trail, b_gap, b_busy, b_excl;
    int f_lead, f_tgl, f_trail, f_gap, f_busy, f_excl;
    int a_tgl, e_tgl, a_busy, e_busy;
    nl = dly_v(lp, ls);
    p  = bp_v(bp) * bs_v(bs) / (1 + dbl);
    hh = (p + 1) / 2;
    tb_end = nl + nper * p;
    nt = dly_v(tp, ts);
    ng = dly_v(gp, gs);
    t_end = tb_end + nt + ng;
    {b_lead, b_tgl, b_trail, b_gap, b_busy, b_excl} = '0;
    {f_lead, f_tgl, f_trail, f_gap, f_busy, f_excl} = '0;
    {a_tgl, e_tgl, a_busy, e_busy} = '0;
    @(negedge clk_i);
    baud_pre_i = 2'(bp); baud_scl_i = 4'(bs); dbl_rate_i = 1'(dbl);
    lead_pre_i = 2'(lp); lead_scl_i = 4'(ls);
    trail_pre_i = 2'(tp); trail_scl_i = 4'(ts);
    gap_pre_i = 2'(gp); gap_scl_i = 4'(gs);
    start_i = 1'b1;
    for (int t = 1; t <= t_end + 1; t++) begin
      bit el, etg, etr, eg, eb;
      int k;
      @(negedge clk_i);
      k   = t - nl;
      el  = (t == nl);
      etg = (t > nl) && (t <= tb_end) && ((k % p) == hh || (k % p) == 0);
      etr = (t == tb_end + nt);
      eg  = (t == t_end);
      eb  = (t <= t_end);
      if (lead_done_o !== el)  begin if (b_lead == 0) f_lead = t; b_lead++; end
      if (sck_tgl_o !== etg)   begin if (b_tgl == 0) begin f_tgl = t; a_tgl = int'(sck_tgl_o); e_tgl = int'(etg); end b_tgl++; end
      if (trail_done_o !== etr) begin if (b_trail == 0) f_trail = t; b_trail++; end
      if (gap_done_o !== eg)   begin if (b_gap == 0) f_gap = t; b_gap++; end
      if (busy_o !== eb)       begin if (b_busy == 0) begin f_busy = t; a_busy = int'(busy_o); e_busy = int'(eb); end b_busy++; end
      if ((int'(sck_tgl_o) + int'(lead_done_o) + int'(trail_done_o) + int'(gap_done_o)) > 1)
        begin if (b_excl == 0) f_excl = t; b_excl++; end
      start_i     = restart && (t == 3);
      bits_done_i = (t == tb_end);
      if (scramble && t == 1) begin
        baud_pre_i = 2'($urandom); baud_scl_i = 4'($urandom); dbl_rate_i = 1'($urandom);
        lead_pre_i = 2'($urandom); lead_scl_i = 4'($urandom);
        trail_pre_i = 2'($urandom); trail_scl_i = 4'($urandom);
        gap_pre_i = 2'($urandom); gap_scl_i = 4'($urandom);
      end
    end
    bits_done_i = 1'b0;
    start_i = 1'b0;
    chk("R3 lead_done", b_lead, f_lead, ~int'(el_at(f_lead, nl)), int'(el_at(f_lead, nl)));
    chk("R4 R5 sck_tgl", b_tgl, f_tgl, a_tgl, e_tgl);
    chk("R6 R7 trail_done", b_trail, f_trail, int'(f_trail != tb_end + nt), int'(f_trail == tb_end + nt));
    chk("R8 gap_done", b_gap, f_gap, int'(f_gap != t_end), int'(f_gap == t_end));
    chk("R2 R8 R9 busy", b_busy, f_busy, a_busy, e_busy);
    chk("R10 exclusive pulses", b_excl, f_excl, 2, 1);
  endtask

  function automatic bit el_at(int t, int nl);
    return t == nl;
  endfunction

  initial begin
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_chk++;
    if ({busy_o, sck_tgl_o, lead_done_o, trail_done_o, gap_done_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: act %b exp 00000",
               {busy_o, sck_tgl_o, lead_done_o, trail_done_o, gap_done_o});
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if ({busy_o, sck_tgl_o, lead_done_o, trail_done_o, gap_done_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 after release: act %b exp 00000",
               {busy_o, sck_tgl_o, lead_done_o, trail_done_o, gap_done_o});
    end
    // R5 fastest: toggle every cycle
    run_frame(0, 0, 1, 0, 0, 0, 0, 0, 0, 4, 1'b0, 1'b0);
    // R5 odd period 3 in double rate: halves 2 and 1
    run_frame(1, 0, 1, 1, 0, 0, 1, 1, 0, 3, 1'b0, 1'b0);
    // R4 even split, prescale 5 scale 4
    run_frame(2, 1, 0, 2, 1, 3, 0, 0, 2, 2, 1'b1, 1'b1);
    // R4 power-of-two scaler region
    run_frame(0, 9, 0, 0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b0);
    // R3 R7 R8 long delays
    run_frame(3, 0, 0, 3, 11, 1, 3, 2, 4, 1, 1'b0, 1'b1);
    for (int i = 0; i < 25; i++) begin
      run_frame($urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 1),
                $urandom_range(0, 3), $urandom_range(0, 6), $urandom_range(0, 3),
                $urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 6),
                $urandom_range(1, 2), 1'($urandom), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule